// File: doc/BRIEF.md
# Exception Return Status Shifter

This block performs the status-word update that happens when a processor returns from an exception handler or from a non-maskable interrupt handler. The status word holds a stack of saved mode and flag fields. A return pops one level of that stack with a masked right shift. The two most significant bits stay where they are. The two bits below them are thrown away. Everything below those moves down by ten places.

After the pop, two more changes are made. If the popped state says the processor is going back to user mode, the live stack pointer is saved as the kernel stack pointer, and the user stack pointer becomes the live one. A pending flag is set unless a restart flag was set in the status before the shift. A return from a non-maskable interrupt also always sets an NMI-return flag.

The surrounding pipeline gives the block the current status word and both stack pointers, together with a one-cycle strobe for the kind of return. One clock later it reads back the new status, the new stack pointer and the saved kernel stack pointer. A one-cycle done pulse marks that moment. The flag bit positions are parameters.

Top module: `exc_return_unit`

## Requirements
- R1: While reset is held, and after it is released, `status_o`, `sp_o` and `ksp_o` are all zero and `done_o` is low, until the first return strobe.
- R2: One clock after a return strobe, `status_o` holds the following value:
  - bits 31:30 of `status_i` in the same place;
  - bits 27:0 of `status_i` shifted right by 10 (zero fill);
  - bits 29:28 of `status_i` discarded;
  - apart from the flag changes of R3 and R6.
- R3: The pending flag (default bit 7 of the result) is forced to 1 when the restart flag (default bit 8 of `status_i`, taken before the shift) is 0. When the restart flag is 1, the pending flag keeps the value produced by the shift.
- R4: When the user-mode flag (default bit 6) of the shifted status is 1, then one clock after the strobe `ksp_o` equals the `sp_i` that was given with the strobe, and `sp_o` equals `usp_i`.
- R5: When that user-mode flag is 0, then one clock after the strobe `sp_o` equals `sp_i` and `ksp_o` keeps its previous value.
- R6: An NMI return (`ret_nmi_i`) always sets the NMI-return flag (default bit 9) in the result. An exception return (`ret_exc_i`) leaves that bit as the shift produced it.
- R7: When `ret_exc_i` and `ret_nmi_i` are both high in the same cycle, the block behaves as an NMI return.
- R8: `done_o` is high exactly in the cycle after a strobe. In cycles without a strobe, `status_o`, `sp_o` and `ksp_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_exc_i | input | 1 | One-cycle strobe: exception return |
| ret_nmi_i | input | 1 | One-cycle strobe: NMI return |
| status_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| status_o | output | 32 | Status word after the return |
| sp_o | output | 32 | Stack pointer after the return |
| ksp_o | output | 32 | Saved kernel stack pointer |
| done_o | output | 1 | Pulses for one cycle when the results are updated |

## Verification
A wrong shift amount or a wrong mask shows up in `status_o` in the very cycle after the strobe. Bits land in the wrong place, or the discarded pair leaks through. A faulty flag rule shows as a single wrong bit at a fixed position in that same cycle. A stack-swap fault differs: `ksp_o` is held state, so a missed or stray capture may only show later. It is visible at the next return, or as a changed `ksp_o` after a return to kernel mode. For that reason the bench compares all three outputs after every return, including those that should leave `ksp_o` alone.

// File: rtl/exc_return_pkg.sv
// Shared types for the exception return unit.
// Assumes: the two return strobes are each high for at most one cycle.
package exc_return_pkg;
    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_EXC  = 2'd1,
        RET_NMI  = 2'd2
    } ret_kind_e;
endpackage

// File: rtl/status_pop.sv
// Combinational pop of the status word.
// What it does:
//   - keeps the top KEEP_HI bits in place;
//   - drops the DROP bits below them;
//   - shifts the remaining low bits right by SHIFT;
//   - applies the pending-flag and NMI-flag rules.
// Assumes: every flag position lies below W.
module status_pop #(
    parameter int W       = 32,
    parameter int KEEP_HI = 2,
    parameter int DROP    = 2,
    parameter int SHIFT   = 10,
    parameter int P_BIT   = 7,
    parameter int R_BIT   = 8,
    parameter int M_BIT   = 9
) (
    input  logic [W-1:0] old_i,
    input  logic         nmi_i,
    output logic [W-1:0] new_o
);
    localparam int LOW_W = W - KEEP_HI - DROP;
    localparam logic [W-1:0] HI_MASK  = {{KEEP_HI{1'b1}}, {(W-KEEP_HI){1'b0}}};
    localparam logic [W-1:0] LOW_MASK = {{(W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

    // Build the popped word, then apply the flag rules.
    always_comb begin
        new_o = (old_i & HI_MASK) | ((old_i & LOW_MASK) >> SHIFT);
        if (!old_i[R_BIT]) new_o[P_BIT] = 1'b1;
        if (nmi_i)         new_o[M_BIT] = 1'b1;
    end
endmodule

// File: rtl/stack_swap.sv
// Chooses the next stack pointer, and says whether the kernel stack
// pointer must be captured.
// Assumes: user_mode_i is taken from the already-popped status word.
module stack_swap #(
    parameter int W = 32
) (
    input  logic         user_mode_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] usp_i,
    output logic [W-1:0] sp_next_o,
    output logic         ksp_we_o
);
    // Going back to user mode swaps in the user stack pointer.
    always_comb begin
        sp_next_o = user_mode_i ? usp_i : sp_i;
        ksp_we_o  = user_mode_i;
    end
endmodule

// File: rtl/exc_return_unit.sv
// Top of the exception return unit.
// What it does:
//   - decodes the return strobes (both high means an NMI return);
//   - pops the status word and picks the stack pointer;
//   - registers the results, one cycle of latency.
// Assumes: synchronous active-low reset; the strobes last one cycle.
module exc_return_unit #(
    parameter int W       = 32,
    parameter int KEEP_HI = 2,
    parameter int DROP    = 2,
    parameter int SHIFT   = 10,
    parameter int U_BIT   = 6,
    parameter int P_BIT   = 7,
    parameter int R_BIT   = 8,
    parameter int M_BIT   = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ret_exc_i,
    input  logic         ret_nmi_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] usp_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] ksp_o,
    output logic         done_o
);
    import exc_return_pkg::*;

    ret_kind_e    kind;
    logic [W-1:0] popped;
    logic [W-1:0] sp_next;
    logic         ksp_we;

    // Decode the strobes; NMI wins when both are high.
    always_comb begin
        if (ret_nmi_i)      kind = RET_NMI;
        else if (ret_exc_i) kind = RET_EXC;
        else                kind = RET_NONE;
    end

    status_pop #(
        .W(W), .KEEP_HI(KEEP_HI), .DROP(DROP), .SHIFT(SHIFT),
        .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
    ) u_pop (
        .old_i (status_i),
        .nmi_i (kind == RET_NMI),
        .new_o (popped)
    );

    stack_swap #(.W(W)) u_swap (
        .user_mode_i (popped[U_BIT]),
        .sp_i        (sp_i),
        .usp_i       (usp_i),
        .sp_next_o   (sp_next),
        .ksp_we_o    (ksp_we)
    );

    // Register the results when a return occurs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            sp_o     <= '0;
            ksp_o    <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= (kind != RET_NONE);
            if (kind != RET_NONE) begin
                status_o <= popped;
                sp_o     <= sp_next;
                if (ksp_we) ksp_o <= sp_i;
            end
        end
    end

    // R8: done follows a strobe by exactly one cycle.
    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_exc_i || ret_nmi_i) |=> done_o);
    // R8: outputs hold when there is no strobe.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_exc_i && !ret_nmi_i) |=> ($stable(status_o) && $stable(sp_o) && $stable(ksp_o) && !done_o));
    // R3: pending flag set when restart was clear.
    a_r3_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_exc_i || ret_nmi_i) && !status_i[R_BIT]) |=> status_o[P_BIT]);
    // R6 / R7: an NMI return sets the NMI-return flag.
    a_r6_nmi_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ret_nmi_i |=> status_o[M_BIT]);
    // R4: a return to user mode loads the user stack pointer.
    a_r4_user_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o[U_BIT]) |-> (sp_o == $past(usp_i) && ksp_o == $past(sp_i)));
    // R5: a return to kernel mode keeps sp and the saved kernel sp.
    a_r5_kernel_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !status_o[U_BIT]) |-> (sp_o == $past(sp_i) && $stable(ksp_o)));
endmodule

// File: tb/sim_exc_return_unit.sv
module sim_exc_return_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_exc_i = 1'b0, ret_nmi_i = 1'b0;
    logic [31:0] status_i = '0, sp_i = '0, usp_i = '0;
    logic [31:0] status_o, sp_o, ksp_o;
    logic        done_o;
    int          total = 0, bad = 0;
    logic [31:0] m_ksp = '0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    exc_return_unit u0 (
        .clk(clk), .rst_n(rst_n), .ret_exc_i(ret_exc_i), .ret_nmi_i(ret_nmi_i),
        .status_i(status_i), .sp_i(sp_i), .usp_i(usp_i),
        .status_o(status_o), .sp_o(sp_o), .ksp_o(ksp_o), .done_o(done_o)
    );

    // Expected status after a return (R2, R3, R6).
    function automatic logic [31:0] exp_status(logic [31:0] s, bit nmi);
        logic [31:0] r;
        r = {s[31:30], 30'd0} | ({4'd0, s[27:0]} >> 10);
        if (!s[8]) r[7] = 1'b1;
        if (nmi)   r[9] = 1'b1;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Issue one return and check all outputs one cycle later.
    task automatic do_ret(bit e, bit n, logic [31:0] s, logic [31:0] sp, logic [31:0] usp, string req);
        logic [31:0] es, esp;
        bit nmi;
        nmi = n;
        @(negedge clk);
        ret_exc_i = e; ret_nmi_i = n; status_i = s; sp_i = sp; usp_i = usp;
        es = exp_status(s, nmi);
        if (es[6]) begin esp = usp; m_ksp = sp; end else esp = sp;
        @(negedge clk);
        ret_exc_i = 1'b0; ret_nmi_i = 1'b0;
        status_i = $urandom; sp_i = $urandom; usp_i = $urandom;
        chk({req, " status"}, status_o, es);
        chk({req, " sp"}, sp_o, esp);
        chk({req, " ksp"}, ksp_o, m_ksp);
        chk({req, " done"}, {31'd0, done_o}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 status", status_o, 0);
        chk("R1 done", {31'd0, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ksp", ksp_o, 0);
        chk("R1 sp", sp_o, 0);
        // Directed corner cases.
        do_ret(1, 0, 32'hFFFF_FFFF, 32'h1000, 32'h2000, "R2/R3 all ones");
        do_ret(1, 0, 32'h3000_0000, 32'h1100, 32'h2100, "R2 dropped bits");
        do_ret(1, 0, 32'hC000_0000, 32'h1200, 32'h2200, "R2 kept bits");
        do_ret(1, 0, 32'h0001_0100, 32'h1300, 32'h2300, "R4 user with R set");
        do_ret(1, 0, 32'h0000_0000, 32'h1400, 32'h2400, "R5 kernel keeps ksp");
        do_ret(0, 1, 32'h0000_0000, 32'h1500, 32'h2500, "R6 nmi");
        do_ret(1, 1, 32'h0000_0100, 32'h1600, 32'h2600, "R7 both strobes");
        do_ret(1, 0, 32'h0000_0100, 32'h1700, 32'h2700, "R3 restart set");
        // R8: idle cycles hold the outputs.
        begin
            logic [31:0] hs, hp, hk;
            hs = status_o; hp = sp_o; hk = ksp_o;
            repeat (3) @(negedge clk);
            chk("R8 hold status", status_o, hs);
            chk("R8 hold sp", sp_o, hp);
            chk("R8 hold ksp", ksp_o, hk);
            chk("R8 done low", {31'd0, done_o}, 0);
        end
        // Random returns.
        for (int i = 0; i < 300; i++) begin
            bit e, n;
            e = $urandom_range(0, 1);
            n = $urandom_range(0, 1);
            if (!e && !n) e = 1;
            do_ret(e, n, $urandom, $urandom, $urandom, "R2-mix random");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule